// File: doc/BRIEF.md
# Multi-Mode PWM/PDM Motor Drive Generator

This block turns a signed duty command into a pair of motor drive lines and an active-low enable line. A two-bit mode input selects one of four output encodings. The first is a PWM wave with a direction line. The second is an up/down pair, where the PWM goes to one line or the other depending on sign. The third is a first-order pulse-density train with a direction line. The fourth is a direction line with a PWM wave for locked-antiphase bridges. Two separate clock dividers set the PWM counter rate and the pulse-density slot rate.

The command is sign-extended and reduced to a sign and a magnitude. A magnitude above full scale saturates at full scale. Duty and mode are captured only when a PWM period wraps, so a change in the middle of a period never produces a clipped or stretched pulse. When the enable input is low, the enable output goes high and both drive lines go low. The counters keep running while the block is disabled.

Top module: `pwm_pdm_gen`

## Requirements
- R1: While rst_n is low and on the first clock after reset is released, drv_en_n is 1 and drv_a and drv_b are 0.
- R2: Mode code 0 (PWM and direction): drv_a carries the PWM wave. drv_b is the direction bit, which is 1 for a negative command and 0 otherwise.
- R3: Mode code 1 (up/down): for a positive command, the PWM goes on drv_a and drv_b is 0. For a negative command, the PWM goes on drv_b and drv_a is 0. The two lines are never high together.
- R4: Mode code 2 (pulse density and direction): drv_a carries the pulse-density train and drv_b is the direction bit.
- R5: Mode code 3 (locked antiphase): drv_a is the direction bit and drv_b carries the PWM wave.
- R6: When enable is sampled low, the next clock drives drv_en_n to 1 and drv_a and drv_b to 0. When enable is sampled high, the next clock drives drv_en_n to 0.
- R7: The PWM period counter advances once every pwm_div+1 clocks and runs from 0 to FS-1, where FS = 2^MAG_W-1. The PWM wave is high while the counter is below the captured magnitude. A magnitude of FS therefore gives a wave that is always high.
- R8: The magnitude is |duty_cmd| limited to FS. A command beyond ±FS, including the most negative code, saturates at full scale with the sign preserved.
- R9: Every pdm_div+1 clocks, a MAG_W-bit accumulator adds the magnitude. The pulse-density output is 1 for that whole slot exactly when the addition carries. A magnitude of half of 2^MAG_W gives a square wave at half the slot rate.
- R10: Duty and mode are captured only when the period counter wraps from FS-1 to 0. A pulse already in progress keeps the length set by the previous command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run request; low forces the drive lines inactive |
| mode | input | 2 | Output encoding select, codes 0 to 3 |
| duty_cmd | input | CMD_W | Signed duty command |
| pwm_div | input | DIV_W | PWM counter rate divider (clocks per step minus one) |
| pdm_div | input | DIV_W | Pulse-density slot divider (clocks per slot minus one) |
| drv_a | output | 1 | Drive line A |
| drv_b | output | 1 | Drive line B |
| drv_en_n | output | 1 | Active-low drive enable |

## Verification
The assertions take for granted that rst_n is held low for at least one clock before any property is judged. They also assume the mode and duty inputs hold a defined level, because the captured copies are compared against later output values. Stimulus changes only at falling clock edges and always starts with reset asserted. Each new command is then held for more than two full PWM periods before high times are counted, so every counting window falls inside a period whose captured values are already settled.

// File: rtl/pwm_pdm_gen.sv
module pwm_pdm_gen #(
  parameter int MAG_W = 12,
  parameter int CMD_W = 16,
  parameter int DIV_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [1:0]              mode,
  input  logic signed [CMD_W-1:0] duty_cmd,
  input  logic [DIV_W-1:0]        pwm_div,
  input  logic [DIV_W-1:0]        pdm_div,
  output logic                    drv_a,
  output logic                    drv_b,
  output logic                    drv_en_n
);

  localparam logic [MAG_W-1:0] FS      = {MAG_W{1'b1}};
  localparam logic [MAG_W-1:0] LAST    = FS - 1'b1;
  localparam logic [CMD_W:0]   FS_WIDE = {{(CMD_W+1-MAG_W){1'b0}}, FS};

  localparam logic [1:0] M_PWM_DIR = 2'd0;
  localparam logic [1:0] M_UP_DN   = 2'd1;
  localparam logic [1:0] M_PDM_DIR = 2'd2;
  localparam logic [1:0] M_DIR_PWM = 2'd3;

  logic [CMD_W:0]   cmd_ext, cmd_abs;
  logic [MAG_W-1:0] cmd_mag;
  logic             cmd_neg;

  assign cmd_neg = duty_cmd[CMD_W-1];
  assign cmd_ext = {duty_cmd[CMD_W-1], duty_cmd};
  assign cmd_abs = cmd_neg ? (~cmd_ext + 1'b1) : cmd_ext;
  assign cmd_mag = (cmd_abs > FS_WIDE) ? FS : cmd_abs[MAG_W-1:0];

  logic [DIV_W-1:0] pwm_pre, pdm_pre;
  logic             pwm_tick, slot_tick;
  logic [MAG_W-1:0] pcnt;
  logic             wrap;

  assign pwm_tick  = (pwm_pre >= pwm_div);
  assign slot_tick = (pdm_pre >= pdm_div);
  assign wrap      = pwm_tick && (pcnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwm_pre <= '0;
      pdm_pre <= '0;
      pcnt    <= '0;
    end else begin
      pwm_pre <= pwm_tick  ? '0 : pwm_pre + 1'b1;
      pdm_pre <= slot_tick ? '0 : pdm_pre + 1'b1;
      if (pwm_tick) pcnt <= (pcnt == LAST) ? '0 : pcnt + 1'b1;
    end
  end

  logic [MAG_W-1:0] lat_mag;
  logic             lat_sign;
  logic [1:0]       lat_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_mag  <= '0;
      lat_sign <= 1'b0;
      lat_mode <= M_PWM_DIR;
    end else if (wrap) begin
      lat_mag  <= cmd_mag;
      lat_sign <= cmd_neg;
      lat_mode <= mode;
    end
  end

  logic [MAG_W-1:0] acc;
  logic [MAG_W:0]   acc_sum;
  logic             pdm_bit;

  assign acc_sum = {1'b0, acc} + {1'b0, lat_mag};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      pdm_bit <= 1'b0;
    end else if (slot_tick) begin
      acc     <= acc_sum[MAG_W-1:0];
      pdm_bit <= acc_sum[MAG_W];
    end
  end

  logic pwm_hi, nx_a, nx_b;
  assign pwm_hi = (pcnt < lat_mag);

  always_comb begin
    unique case (lat_mode)
      M_PWM_DIR: begin nx_a = pwm_hi;              nx_b = lat_sign;            end
      M_UP_DN:   begin nx_a = pwm_hi && !lat_sign; nx_b = pwm_hi && lat_sign;  end
      M_PDM_DIR: begin nx_a = pdm_bit;             nx_b = lat_sign;            end
      default:   begin nx_a = lat_sign;            nx_b = pwm_hi;              end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_a    <= 1'b0;
      drv_b    <= 1'b0;
      drv_en_n <= 1'b1;
    end else begin
      drv_a    <= enable && nx_a;
      drv_b    <= enable && nx_b;
      drv_en_n <= !enable;
    end
  end

  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!enable) |-> (drv_en_n && !drv_a && !drv_b));

  a_r6_enabled_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable) |-> !drv_en_n);

  a_r3_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lat_mode == M_UP_DN) |-> !(drv_a && drv_b));

  a_r2_dir_on_b: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable && lat_mode == M_PWM_DIR) |-> (drv_b == $past(lat_sign)));

  a_r4_dir_on_b: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable && lat_mode == M_PDM_DIR) |-> (drv_b == $past(lat_sign)));

  a_r5_dir_on_a: assert property (@(posedge clk) disable iff (!rst_n)
    $past(enable && lat_mode == M_DIR_PWM) |-> (drv_a == $past(lat_sign)));

  a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt < FS);

  a_r10_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wrap) |-> ($stable(lat_mag) && $stable(lat_sign) && $stable(lat_mode)));

  a_r9_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(slot_tick) |-> $stable(pdm_bit));

endmodule

// File: tb/tb_pwm_pdm_gen.sv
module tb_pwm_pdm_gen;
  localparam int MAG_W = 8;
  localparam int CMD_W = 16;
  localparam int DIV_W = 8;
  localparam int FS    = (1 << MAG_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] mode = 2'd0;
  logic signed [CMD_W-1:0] duty_cmd = '0;
  logic [DIV_W-1:0] pwm_div = '0;
  logic [DIV_W-1:0] pdm_div = '0;
  logic drv_a, drv_b, drv_en_n;

  always #5 clk = ~clk;

  pwm_pdm_gen #(.MAG_W(MAG_W), .CMD_W(CMD_W), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .duty_cmd(duty_cmd),
    .pwm_div(pwm_div), .pdm_div(pdm_div),
    .drv_a(drv_a), .drv_b(drv_b), .drv_en_n(drv_en_n));

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  typedef struct packed {
    logic [1:0]  md;
    logic [15:0] cmd;
    logic [15:0] exp_a;
    logic [15:0] exp_b;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 16'sd100,    16'd100, 16'd0},
    '{2'd0, -16'sd100,   16'd100, 16'd255},
    '{2'd1, 16'sd100,    16'd100, 16'd0},
    '{2'd1, -16'sd60,    16'd0,   16'd60},
    '{2'd3, 16'sd77,     16'd0,   16'd77},
    '{2'd3, -16'sd77,    16'd255, 16'd77},
    '{2'd0, 16'sd0,      16'd0,   16'd0},
    '{2'd0, 16'sd300,    16'd255, 16'd0},
    '{2'd1, -16'sd32768, 16'd0,   16'd255},
    '{2'd3, 16'sd255,    16'd0,   16'd255}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int clocks);
    repeat (clocks) @(negedge clk);
  endtask

  task automatic count_win(input int n, output int ca, output int cb);
    ca = 0; cb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ca += int'(drv_a);
      cb += int'(drv_b);
    end
  endtask

  initial begin
    int ca, cb, toggles, prev, len;
    @(negedge clk);
    @(negedge clk);
    check("R1 en_n in reset", int'(drv_en_n), 1);
    check("R1 a|b in reset", int'(drv_a) + int'(drv_b), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 en_n after reset", int'(drv_en_n), 1);
    check("R1 a|b after reset", int'(drv_a) + int'(drv_b), 0);
    enable = 1'b1;
    @(negedge clk);
    check("R6 en_n low when enabled", int'(drv_en_n), 0);

    for (int v = 0; v < NV; v++) begin
      mode = VEC[v].md;
      duty_cmd = VEC[v].cmd;
      settle(2 * FS + 4);
      count_win(FS, ca, cb);
      // R2 R3 R5 R7 R8: high clocks of each line per period
      check($sformatf("R2/R3/R5/R7/R8 vec%0d drv_a", v), ca, int'(VEC[v].exp_a));
      check($sformatf("R2/R3/R5/R7/R8 vec%0d drv_b", v), cb, int'(VEC[v].exp_b));
    end

    // R7: divided counter rate
    mode = 2'd0; duty_cmd = 16'sd50; pwm_div = 8'd1;
    settle(4 * FS + 8);
    count_win(2 * FS, ca, cb);
    check("R7 pwm_div=1 high clocks", ca, 100);
    pwm_div = 8'd0;

    // R6: disable
    enable = 1'b0;
    @(negedge clk);
    check("R6 en_n high when disabled", int'(drv_en_n), 1);
    count_win(FS, ca, cb);
    check("R6 lines quiet while disabled", ca + cb, 0);
    enable = 1'b1;

    // R4 R9: pulse density, 50% with slot = 1 clock
    mode = 2'd2; duty_cmd = 16'sd128; pdm_div = 8'd0;
    settle(2 * FS + 4);
    toggles = 0; prev = int'(drv_a);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (int'(drv_a) != prev) toggles++;
      prev = int'(drv_a);
    end
    check("R9 50% toggles every slot", toggles, 256);
    check("R4 dir low for positive", int'(drv_b), 0);

    // R9: slot = 2 clocks, square wave runs of 2
    pdm_div = 8'd1;
    settle(8);
    count_win(256, ca, cb);
    check("R9 slot=2 high clocks", ca, 128);
    toggles = 0; prev = int'(drv_a);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (int'(drv_a) != prev) toggles++;
      prev = int'(drv_a);
    end
    check("R9 slot=2 toggles", toggles, 128);

    // R4 R9: quarter density, negative sign
    pdm_div = 8'd0; duty_cmd = -16'sd64;
    settle(2 * FS + 4);
    count_win(256, ca, cb);
    check("R9 quarter density pulses", ca, 64);
    check("R4 dir high for negative", cb, 256);

    // R10: change mid-pulse, current pulse keeps old length
    mode = 2'd0; duty_cmd = 16'sd40;
    settle(2 * FS + 4);
    prev = int'(drv_a);
    forever begin
      @(negedge clk);
      if (prev == 0 && drv_a) break;
      prev = int'(drv_a);
    end
    len = 1;
    forever begin
      @(negedge clk);
      if (len == 4) duty_cmd = 16'sd90;
      if (drv_a) len++; else break;
    end
    check("R10 in-flight pulse length", len, 40);
    forever begin
      @(negedge clk);
      if (drv_a) break;
    end
    len = 1;
    forever begin
      @(negedge clk);
      if (drv_a) len++; else break;
    end
    check("R10 next pulse length", len, 90);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule